// File: doc/BRIEF.md
# Completion Interrupt Coalescer

The block sits between a completion source and an interrupt controller. It counts completion pulses and keeps the interrupt request low until one of two conditions holds. Either enough completions have built up to meet a count threshold, or a latency timer has run out. The timer starts when the first completion of a window arrives. It advances on a coarse tick of nominally 64 ns, which is made by dividing the block clock by a parameter. When the interrupt service routine acknowledges, a new window opens.

Both thresholds sit in one 32-bit setup word. Software may rewrite this word at any time, including while completions are pending. A typical case is lowering the count threshold to follow the current outstanding depth. An all-zero setup word turns coalescing off, and every completion then raises the request.

Top module: `coal_irq_ctrl`

## Requirements
- R1: The setup word carries the latency limit in bits [15:0], counted in ticks, and the completion-count threshold in bits [24:16]. A write of `cfg_wdata_i` with `cfg_we_i` high is readable on `cfg_rdata_o` one cycle later.
- R2: Setup bits [31:25] always read as zero, whatever value was written to them.
- R3: While the setup word is all zeros, each completion pulse drives `irq_o` high on the next cycle.
- R4: While coalescing is on with a nonzero count threshold N, `irq_o` rises one cycle after the edge at which the pending completion count reaches N.
- R5: The latency timer restarts from zero on the completion that opens a window. It then advances by one on each divider tick, and `irq_o` rises one cycle after the edge at which the elapsed ticks reach a nonzero latency limit.
- R6: A count threshold of zero together with a nonzero latency limit means that only the timer raises `irq_o`, however many completions arrive.
- R7: A latency limit of zero together with a nonzero count threshold means that only the count raises `irq_o`, however long completions stay pending.
- R8: Once high, `irq_o` stays high until `ack_i`. An acknowledge with no completion in the same cycle clears the request, the pending count and the timer.
- R9: A completion in the same cycle as `ack_i` opens the next window: it counts as one pending completion and starts the timer. With coalescing off, it raises `irq_o` again.
- R10: A setup write takes effect on the following cycle and applies to completions that are already pending. Lowering the threshold to or below the pending count raises `irq_o` one cycle after the write becomes visible.
- R11: The divider tick occurs every `TICK_DIV` clock cycles, counted from reset, and the timer advances only on those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the source of the divided time base |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmpl_i | input | 1 | One-cycle completion pulse |
| ack_i | input | 1 | Interrupt acknowledge, opens a new window |
| cfg_we_i | input | 1 | Setup word write strobe |
| cfg_wdata_i | input | 32 | Setup word write data |
| cfg_rdata_o | output | 32 | Current setup word, reserved bits zero |
| irq_o | output | 1 | Coalesced interrupt request |

## Verification
The acknowledge and a new completion can fall in the same cycle, and so can a setup write and the crossing of a threshold. The bench places completions on the exact cycle of the acknowledge, with coalescing both on and off. It then checks that the next window starts with one pending completion, which it judges by how many further pulses are needed before the request returns. It also rewrites the threshold while completions are held pending and while random traffic is running. A behavioural model of windows, ticks and setup updates predicts the request line every cycle.

// File: rtl/coal_pkg.sv
package coal_pkg;
    localparam int CFG_W     = 32;
    localparam int LAT_W     = 16;
    localparam int CNT_W     = 9;
    localparam int LAT_LSB   = 0;
    localparam int CNT_LSB   = 16;
    localparam int USED_W    = CNT_LSB + CNT_W;
    localparam logic [CFG_W-1:0] CFG_MASK = CFG_W'((64'd1 << USED_W) - 64'd1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [LAT_W-1:0] tmr;
        logic             run;
        logic             irq;
    } win_state_t;
endpackage

// File: rtl/coal_tick_div.sv
module coal_tick_div #(
    parameter int TICK_DIV = 13
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    generate
        if (TICK_DIV <= 1) begin : g_pass
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(TICK_DIV);
            localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);
            logic [DW-1:0] div_d, div_q;

            always_comb begin
                div_d = (div_q == LAST) ? '0 : div_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) div_q <= '0;
                else        div_q <= div_d;
            end

            assign tick_o = (div_q == LAST);

            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o); // R11
        end
    endgenerate
endmodule

// File: rtl/coal_cfg_reg.sv
module coal_cfg_reg
    import coal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CFG_W-1:0] wdata_i,
    output logic [CFG_W-1:0] rdata_o,
    output logic [CNT_W-1:0] thr_o,
    output logic [LAT_W-1:0] lat_o,
    output logic             off_o
);
    logic [CFG_W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = we_i ? (wdata_i & CFG_MASK) : cfg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign rdata_o = cfg_q;
    assign thr_o   = cfg_q[CNT_LSB +: CNT_W];
    assign lat_o   = cfg_q[LAT_LSB +: LAT_W];
    assign off_o   = (cfg_q == '0);

    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> rdata_o[USED_W-1:0] == $past(wdata_i[USED_W-1:0])); // R1
    AST_CFG_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> rdata_o[CFG_W-1:USED_W] == '0); // R2
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(rdata_o)); // R10
endmodule

// File: rtl/coal_window.sv
module coal_window
    import coal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmpl_i,
    input  logic             ack_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] thr_i,
    input  logic [LAT_W-1:0] lat_i,
    input  logic             off_i,
    output logic             irq_o
);
    win_state_t st_d, st_q;
    logic cnt_hit, tmr_hit, fire;

    always_comb begin
        st_d = st_q;
        if (ack_i) begin
            st_d.irq = 1'b0;
            st_d.cnt = CNT_W'(cmpl_i);
            st_d.run = cmpl_i;
            st_d.tmr = '0;
        end else begin
            if (cmpl_i && st_q.cnt == '0) begin
                st_d.run = 1'b1;
                st_d.tmr = '0;
            end else if (st_q.run && tick_i && st_q.tmr != '1) begin
                st_d.tmr = st_q.tmr + 1'b1;
            end
            if (cmpl_i && st_q.cnt != '1) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        cnt_hit = (thr_i != '0) && (st_d.cnt >= thr_i);
        tmr_hit = (lat_i != '0) && st_d.run && (st_d.tmr >= lat_i);
        fire    = off_i ? cmpl_i : (cnt_hit || tmr_hit);
        if (fire) st_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (off_i && cmpl_i) |=> irq_o); // R3
    AST_CNT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_i && !off_i && thr_i != '0 && st_q.cnt >= thr_i) |=> irq_o); // R4
    AST_TMR_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_i && !off_i && lat_i != '0 && st_q.run && st_q.tmr >= lat_i) |=> irq_o); // R5
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i) |=> irq_o); // R8
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !cmpl_i) |=> (!irq_o && st_q.cnt == '0 && !st_q.run)); // R8
    AST_ACK_NEXT_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && cmpl_i) |=> (st_q.cnt == CNT_W'(1) && st_q.run)); // R9
endmodule

// File: rtl/coal_irq_ctrl.sv
module coal_irq_ctrl
    import coal_pkg::*;
#(
    parameter int TICK_DIV = 13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmpl_i,
    input  logic        ack_i,
    input  logic        cfg_we_i,
    input  logic [31:0] cfg_wdata_i,
    output logic [31:0] cfg_rdata_o,
    output logic        irq_o
);
    logic             tick;
    logic [CNT_W-1:0] thr;
    logic [LAT_W-1:0] lat;
    logic             off;

    coal_tick_div #(.TICK_DIV(TICK_DIV)) i_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    coal_cfg_reg i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .rdata_o (cfg_rdata_o),
        .thr_o   (thr),
        .lat_o   (lat),
        .off_o   (off)
    );

    coal_window i_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmpl_i (cmpl_i),
        .ack_i  (ack_i),
        .tick_i (tick),
        .thr_i  (thr),
        .lat_i  (lat),
        .off_i  (off),
        .irq_o  (irq_o)
    );
endmodule

// File: tb/test_coal_irq_ctrl.sv
`timescale 1ns/100ps
module test_coal_irq_ctrl;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmpl = 1'b0;
    logic        ack = 1'b0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // reference model state
    int          m_pend, m_el, m_dv, m_thr, m_lat;
    bit          m_run, m_irq, m_tick, m_fire;
    logic [31:0] m_cfg;

    always #2.5 clk = ~clk;

    coal_irq_ctrl #(.TICK_DIV(DIV)) i_coal_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .cmpl_i(cmpl), .ack_i(ack),
        .cfg_we_i(we), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .irq_o(irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = '0; m_pend = 0; m_el = 0; m_run = 0; m_irq = 0; m_dv = 0;
        end else begin
            m_tick = (m_dv == DIV - 1);
            m_dv   = m_tick ? 0 : m_dv + 1;
            m_thr  = int'((m_cfg >> 16) & 32'h1ff);
            m_lat  = int'(m_cfg & 32'hffff);
            if (ack) begin
                m_irq = 0; m_pend = cmpl ? 1 : 0; m_run = cmpl; m_el = 0;
            end else begin
                if (cmpl && m_pend == 0) begin
                    m_run = 1; m_el = 0;
                end else if (m_run && m_tick && m_el < 65535) begin
                    m_el = m_el + 1;
                end
                if (cmpl && m_pend < 511) m_pend = m_pend + 1;
            end
            if (m_cfg == 0) m_fire = cmpl;
            else m_fire = (m_thr != 0 && m_pend >= m_thr) || (m_lat != 0 && m_run && m_el >= m_lat);
            if (m_fire) m_irq = 1;
            if (we) m_cfg = wdata & 32'h01ff_ffff;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_cmp++;
            if (irq !== m_irq) begin
                n_bad++;
                $display("FAIL %s irq actual=%0b expected=%0b at %0t", cur_req, irq, m_irq, $time);
            end
            n_cmp++;
            if (rdata !== m_cfg) begin
                n_bad++;
                $display("FAIL %s cfg actual=%h expected=%h at %0t", cur_req, rdata, m_cfg, $time);
            end
        end
    end

    task automatic drive(input bit c, input bit a, input bit w, input logic [31:0] d);
        @(negedge clk);
        cmpl = c; ack = a; we = w; wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, '0);
    endtask

    task automatic set_cfg(input logic [31:0] d);
        drive(0, 0, 1, d);
        idle(1);
    endtask

    task automatic pulses(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            drive(1, 0, 0, '0);
            idle(gap);
        end
    endtask

    task automatic expect_irq(input bit v, input string tag);
        @(negedge clk);
        n_cmp++;
        if (irq !== v) begin
            n_bad++;
            $display("FAIL %s directed irq actual=%0b expected=%0b", tag, irq, v);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired during %s", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R8"; expect_irq(0, "R8");

        cur_req = "R2"; set_cfg(32'hFFFF_FFFF);
        cur_req = "R1"; set_cfg(32'h0003_0002);
        set_cfg(32'h0000_0000);

        cur_req = "R3"; pulses(1, 0); expect_irq(1, "R3");
        drive(0, 1, 0, '0); idle(2); pulses(3, 2); drive(0, 1, 0, '0); idle(2);

        cur_req = "R9"; drive(1, 0, 0, '0); drive(1, 1, 0, '0); expect_irq(1, "R9");
        drive(0, 1, 0, '0); idle(2);

        cur_req = "R7"; set_cfg(32'h0004_0000);
        pulses(3, 1); idle(60); expect_irq(0, "R7");
        cur_req = "R4"; pulses(1, 0); expect_irq(1, "R4");
        cur_req = "R8"; idle(30); expect_irq(1, "R8");
        drive(0, 1, 0, '0); expect_irq(0, "R8");

        cur_req = "R6"; set_cfg(32'h0000_0003);
        pulses(20, 0); idle(20);
        drive(0, 1, 0, '0); idle(3);
        cur_req = "R11"; pulses(1, 0); idle(25);
        drive(0, 1, 0, '0); idle(3);

        cur_req = "R5"; set_cfg(32'h0008_0005);
        pulses(2, 6); idle(30);
        drive(0, 1, 0, '0); idle(2);

        cur_req = "R9"; set_cfg(32'h0002_0000);
        pulses(2, 0); drive(1, 1, 0, '0); idle(3); expect_irq(0, "R9");
        pulses(1, 0); expect_irq(1, "R9");
        drive(0, 1, 0, '0); idle(2);

        cur_req = "R10"; set_cfg(32'h000A_0000);
        pulses(5, 1); idle(5); expect_irq(0, "R10");
        set_cfg(32'h0003_0000); expect_irq(1, "R10");
        drive(0, 1, 0, '0); idle(2);

        cur_req = "R10";
        for (int i = 0; i < 3000; i++) begin
            automatic bit c = ($urandom_range(0, 2) == 0);
            automatic bit a = ($urandom_range(0, 14) == 0);
            automatic bit w = ($urandom_range(0, 60) == 0);
            automatic logic [31:0] d = {$urandom_range(0, 127), 25'h0} |
                                       (32'($urandom_range(0, 6)) << 16) |
                                       32'($urandom_range(0, 12));
            if ($urandom_range(0, 9) == 0) d = '0;
            drive(c, a, w, d);
        end
        idle(4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule